// File: doc/BRIEF.md
# Link Output Frame Serializer

This block is the controller side of a serial audio codec link. It runs on the link bit clock and emits a repeating 256-bit frame. Each frame starts with a 16-bit tag slot and is followed by twelve 20-bit slots. Alongside the serial data it drives a frame marker (`sync_o`) that is high for the first 16 bit periods of every frame. The tag announces which slots carry meaningful content, so the receiver can skip empty ones.

A source presents a command address, command data and a left and right PCM sample, each with its own valid flag. The block latches all of them at once on the final bit of the frame in progress, so their values for the coming frame are fixed. It then pulses `rdy_o` for one cycle, which invites the source to set up the following frame. If a command is a read (address bit 19 set), the data slot is suppressed, so the receiver treats the command as read-only.

Top module: `ac_link_tx`

## Requirements
- R1: A frame lasts exactly 256 `bit_clk` periods. `sync_o` rises once per frame and stays high for exactly 16 periods, then stays low for the remaining 240.
- R2: The first serial bit of a frame (tag bit 15) appears on `sdata_o` one `bit_clk` period after `sync_o` rises. The bits then follow in this order: tag bits 15..0, then slots 1 to 12, each slot most-significant bit first.
- R3: Tag bits 14, 13, 12 and 11 carry the effective valid flags of slot 1 (command address), slot 2 (command data), slot 3 (left PCM) and slot 4 (right PCM). Tag bits 10..0 are always 0.
- R4: Tag bit 15 (frame valid) is 1 exactly when at least one of the four effective slot valid flags is 1.
- R5: A slot whose effective valid flag is 0 is sent as 20 zero bits. Slots 5 to 12 are always sent as zeros.
- R6: When `cmd_addr_vld_i` is 1 and `cmd_addr_i[19]` is 1 (a read), slot 2 is treated as invalid: its tag bit is 0 and its data is all zeros, whatever `cmd_data_vld_i` is.
- R7: All parallel inputs and valid flags are sampled on the rising edge that sends the last bit of a frame. Changes at any other time have no effect on the frame being sent.
- R8: `rdy_o` is high for exactly one cycle per frame: the first cycle in which `sync_o` is high.
- R9: While `rst_n` is low, `sync_o`, `sdata_o` and `rdy_o` are 0. On the first rising edge after release, a frame starts: `sync_o` and `rdy_o` go high, and that frame carries the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Link bit clock; every output changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_addr_i | input | 20 | Command address slot content; bit 19 set marks a read |
| cmd_addr_vld_i | input | 1 | Command address slot carries content |
| cmd_data_i | input | 20 | Command write-data slot content |
| cmd_data_vld_i | input | 1 | Command data slot carries content |
| pcm_l_i | input | 20 | Left PCM sample |
| pcm_l_vld_i | input | 1 | Left sample is valid |
| pcm_r_i | input | 20 | Right PCM sample |
| pcm_r_vld_i | input | 1 | Right sample is valid |
| sync_o | output | 1 | Frame marker |
| sdata_o | output | 1 | Serial frame data, most-significant bit first |
| rdy_o | output | 1 | One-cycle pulse: inputs latched, present the next frame |

## Verification
The inputs are sampled on the edge that raises `rdy_o`. The bench therefore loads each vector on the falling edge where it sees `rdy_o`, one full frame before that vector is due. It then finds position j of the vector's frame on the (j+1)-th falling edge after the next `rdy_o`, and `sync_o` and `rdy_o` are compared on the same edges. Frame valid and the slot-2 tag bit are due 2 and 4 edges after the sampling edge; the checker measures those delays with `$past`.

// File: rtl/ac_link_tx.sv
module ac_link_tx #(
  parameter int SLOT_W   = 20,
  parameter int TAG_W    = 16,
  parameter int NSLOT    = 12,
  parameter int SYNC_LEN = 16
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] cmd_addr_i,
  input  logic              cmd_addr_vld_i,
  input  logic [SLOT_W-1:0] cmd_data_i,
  input  logic              cmd_data_vld_i,
  input  logic [SLOT_W-1:0] pcm_l_i,
  input  logic              pcm_l_vld_i,
  input  logic [SLOT_W-1:0] pcm_r_i,
  input  logic              pcm_r_vld_i,
  output logic              sync_o,
  output logic              sdata_o,
  output logic              rdy_o
);
  localparam int FRAME_LEN = TAG_W + NSLOT * SLOT_W;
  localparam int CW        = $clog2(FRAME_LEN);
  localparam int PAD_W     = (NSLOT - 4) * SLOT_W;

  logic [CW-1:0]        cnt, cnt_nx;
  logic                 last;
  logic                 is_read, v_addr, v_data, v_left, v_right;
  logic [TAG_W-1:0]     tag;
  logic [FRAME_LEN-1:0] frame, shreg;

  assign last    = (cnt == CW'(FRAME_LEN - 1));
  assign cnt_nx  = last ? '0 : cnt + 1'b1;

  assign is_read = cmd_addr_vld_i & cmd_addr_i[SLOT_W-1];
  assign v_addr  = cmd_addr_vld_i;
  assign v_data  = cmd_data_vld_i & ~is_read;
  assign v_left  = pcm_l_vld_i;
  assign v_right = pcm_r_vld_i;

  assign tag = {(v_addr | v_data | v_left | v_right),
                v_addr, v_data, v_left, v_right,
                {(TAG_W - 5){1'b0}}};

  assign frame = {tag,
                  v_addr  ? cmd_addr_i : {SLOT_W{1'b0}},
                  v_data  ? cmd_data_i : {SLOT_W{1'b0}},
                  v_left  ? pcm_l_i    : {SLOT_W{1'b0}},
                  v_right ? pcm_r_i    : {SLOT_W{1'b0}},
                  {PAD_W{1'b0}}};

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      cnt     <= CW'(FRAME_LEN - 1);
      shreg   <= '0;
      sync_o  <= 1'b0;
      sdata_o <= 1'b0;
      rdy_o   <= 1'b0;
    end else begin
      cnt     <= cnt_nx;
      sync_o  <= (cnt_nx < CW'(SYNC_LEN));
      sdata_o <= shreg[FRAME_LEN-1];
      shreg   <= last ? frame : {shreg[FRAME_LEN-2:0], 1'b0};
      rdy_o   <= last;
    end
  end
endmodule

module ac_link_tx_chk (
  input logic        bit_clk,
  input logic        rst_n,
  input logic [19:0] cmd_addr_i,
  input logic        cmd_addr_vld_i,
  input logic        cmd_data_vld_i,
  input logic        pcm_l_vld_i,
  input logic        pcm_r_vld_i,
  input logic        sync_o,
  input logic        sdata_o,
  input logic        rdy_o
);
  logic [7:0] k, pos;
  logic       started, run, any_vld, data_eff;

  assign pos      = rdy_o ? 8'd0 : k;
  assign run      = started | rdy_o;
  assign any_vld  = cmd_addr_vld_i | cmd_data_vld_i | pcm_l_vld_i | pcm_r_vld_i;
  assign data_eff = cmd_data_vld_i & ~(cmd_addr_vld_i & cmd_addr_i[19]);

  always_ff @(posedge bit_clk) begin
    if (!rst_n) begin
      k       <= 8'd0;
      started <= 1'b0;
    end else begin
      k       <= pos + 8'd1;
      started <= started | rdy_o;
    end
  end

  // R8
  rdy_in_sync_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rdy_o |-> sync_o);
  // R8
  rdy_single_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);
  // R1
  frame_period_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    started |-> (rdy_o == (k == 8'd0)));
  // R1
  sync_shape_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    run |-> (sync_o == (pos < 8'd16)));
  // R4
  frame_valid_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rdy_o |=> (sdata_o == $past(any_vld, 2)));
  // R6
  read_mask_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rdy_o |=> ##2 (sdata_o == $past(data_eff, 4)));
  // R5
  pad_zero_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (run && ((pos >= 8'd6 && pos <= 8'd16) || pos >= 8'd97 || pos == 8'd0)) |-> !sdata_o);
endmodule

bind ac_link_tx ac_link_tx_chk u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .cmd_addr_i(cmd_addr_i),
  .cmd_addr_vld_i(cmd_addr_vld_i), .cmd_data_vld_i(cmd_data_vld_i),
  .pcm_l_vld_i(pcm_l_vld_i), .pcm_r_vld_i(pcm_r_vld_i),
  .sync_o(sync_o), .sdata_o(sdata_o), .rdy_o(rdy_o)
);

// File: tb/ac_link_tx_bench.sv
`timescale 1ns/1ps
module ac_link_tx_bench;
  logic bit_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] cmd_addr_i, cmd_data_i, pcm_l_i, pcm_r_i;
  logic cmd_addr_vld_i, cmd_data_vld_i, pcm_l_vld_i, pcm_r_vld_i;
  logic sync_o, sdata_o, rdy_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 bit_clk = ~bit_clk;

  ac_link_tx u_ac_link_tx (.*);

  // {addr_vld, data_vld, l_vld, r_vld, addr, data, left, right}
  localparam logic [83:0] VEC [8] = '{
    {4'b1111, 20'h02345, 20'hABCDE, 20'h80001, 20'h7FFFE},
    {4'b0000, 20'h12345, 20'hFFFFF, 20'hFFFFF, 20'h55555},
    {4'b1111, 20'h80A00, 20'h13579, 20'h0F0F0, 20'hF0F0F},
    {4'b0011, 20'hFFFFF, 20'hFFFFF, 20'hC3C3C, 20'h3C3C3},
    {4'b0100, 20'hFFFFF, 20'h96969, 20'h11111, 20'h22222},
    {4'b1000, 20'hFFFFF, 20'hAAAAA, 20'h33333, 20'h44444},
    {4'b0001, 20'h00000, 20'h00000, 20'h00000, 20'hFFFFF},
    {4'b1111, 20'h7FFFF, 20'hFFFFF, 20'hFFFFF, 20'hFFFFF}
  };

  function automatic logic [255:0] exp_frame(input logic [83:0] v);
    logic a, d, l, r;
    logic [19:0] ad, da, pl, pr;
    logic [15:0] tag;
    {a, d, l, r, ad, da, pl, pr} = v;
    d = d & ~(a & ad[19]);                  // R6
    tag = {(a | d | l | r), a, d, l, r, 11'b0}; // R3 R4
    return {tag, a ? ad : 20'h0, d ? da : 20'h0,
            l ? pl : 20'h0, r ? pr : 20'h0, 160'h0}; // R5
  endfunction

  task automatic apply(input logic [83:0] v);
    {cmd_addr_vld_i, cmd_data_vld_i, pcm_l_vld_i, pcm_r_vld_i,
     cmd_addr_i, cmd_data_i, pcm_l_i, pcm_r_i} = v;
  endtask

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] rx, sy, rd, esy, erd;
    apply('0);
    repeat (3) @(negedge bit_clk);
    chk("R9 sync in reset", 256'(sync_o), 256'(0));
    chk("R9 sdata in reset", 256'(sdata_o), 256'(0));
    chk("R9 rdy in reset", 256'(rdy_o), 256'(0));
    apply(VEC[0]);
    rst_n = 1'b1;
    @(negedge bit_clk);
    chk("R9 first edge rdy", 256'(rdy_o), 256'(1));
    chk("R9 first edge sync", 256'(sync_o), 256'(1));

    esy = '0; erd = '0;
    for (int j = 0; j < 256; j++) begin
      esy[j] = (j < 15) || (j == 255); // R1 R2
      erd[j] = (j == 255);             // R8
    end

    for (int i = 0; i < 8; i++) begin
      apply(i < 7 ? VEC[i+1] : VEC[0]);
      rx = '0; sy = '0; rd = '0;
      for (int j = 0; j < 256; j++) begin
        if (j == 100) apply({4'b1111, ~VEC[i][79:0]}); // R7 mid-frame noise
        if (j == 200) apply(i < 7 ? VEC[i+1] : VEC[0]);
        @(negedge bit_clk);
        rx[255-j] = sdata_o;
        sy[j] = sync_o;
        rd[j] = rdy_o;
      end
      chk($sformatf("R2 R3 R4 R5 R6 R7 frame %0d data", i), rx, exp_frame(VEC[i]));
      chk($sformatf("R1 frame %0d sync", i), sy, esy);
      chk($sformatf("R8 frame %0d rdy", i), rd, erd);
    end

    repeat (50) @(negedge bit_clk);
    rst_n = 1'b0;
    @(negedge bit_clk);
    chk("R9 reset mid-frame sync", 256'(sync_o), 256'(0));
    chk("R9 reset mid-frame rdy", 256'(rdy_o), 256'(0));
    apply(VEC[2]);
    rst_n = 1'b1;
    @(negedge bit_clk);
    chk("R9 restart rdy", 256'(rdy_o), 256'(1));
    rx = '0;
    for (int j = 0; j < 256; j++) begin
      @(negedge bit_clk);
      rx[255-j] = sdata_o;
    end
    chk("R6 R9 restart frame data", rx, exp_frame(VEC[2]));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule